// File: doc/BRIEF.md
# Second-Operand Shifter with Carry

This block produces the second operand of a 32-bit data path and the shifter carry that the flag logic consumes. It has no clock. In register mode a source value is moved by one of five operations: left shift, logical right shift, arithmetic right shift, rotate right, and a one-place rotate through the carry flag. The amount comes either from a 5-bit field or from the low byte of a second register. In immediate mode a 12-bit field is expanded into a 32-bit constant: an 8-bit value is rotated right by twice a 4-bit count.

The carry output is the last bit that left the value. When nothing moved, it is the incoming carry. Register-supplied amounts of 32 and above follow fixed rules for each operation, so software can use any byte value as an amount. The ALU, the flag registers and the instruction decode sit outside this block.

Top module: `opsh_top`

## Requirements
- R1: With `shift_kind`=0 (left shift) and an amount of 1 to 31, the operand is the value shifted left with zeros entering at bit 0. The carry is the last bit shifted out, which is bit 32 minus the amount.
- R2: With `shift_kind`=1 (logical right shift) and an amount of 1 to 31, zeros enter at bit 31. The carry is bit (amount-1) of the value.
- R3: With `shift_kind`=2 (arithmetic right shift) and an amount of 1 to 31, copies of bit 31 enter at the top. The carry is bit (amount-1).
- R4: With `shift_kind`=3 (rotate right) and an amount of 1 to 31, bits leaving bit 0 re-enter at bit 31. The carry equals bit 31 of the result.
- R5: With `shift_kind`=4 (rotate through carry), the result is `{carry_in, value[31:1]}` and the carry is value bit 0. The amount inputs have no effect.
- R6: When `amt_sel_reg`=0 the amount is `amt_imm`, zero-extended. When `amt_sel_reg`=1 the amount is `amt_reg[7:0]`, and bits 31:8 of `amt_reg` have no effect.
- R7: For shift kinds 0 to 3, an amount of zero leaves the value unchanged and passes `carry_in` to `carry_out`.
- R8: For kinds 0 and 1, a register amount of exactly 32 gives 0. The carry is bit 0 for kind 0 and bit 31 for kind 1. Any amount above 32 gives 0 with carry 0.
- R9: For kind 2, a register amount of 32 or more gives all result bits and the carry equal to value bit 31.
- R10: For kind 3, the amount is taken modulo 32. A non-zero multiple of 32 leaves the value unchanged, with carry equal to bit 31.
- R11: When `imm_mode`=1, the operand is `imm_field[7:0]` zero-extended and rotated right by 2×`imm_field[11:8]`. For example, 0x40 with count 13 gives 0x00001000, and 0xFF with count 8 gives 0x00FF0000.
- R12: When `imm_mode`=1, the carry is result bit 31 if the count is non-zero, and `carry_in` if the count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| imm_mode | input | 1 | 1 selects immediate expansion, 0 selects register shifting |
| imm_field | input | 12 | Rotate count [11:8] and 8-bit value [7:0] |
| src_val | input | 32 | Value to shift in register mode |
| shift_kind | input | 3 | 0 LSL, 1 LSR, 2 ASR, 3 ROR, 4 rotate through carry |
| amt_sel_reg | input | 1 | 1 takes the amount from `amt_reg`, 0 from `amt_imm` |
| amt_imm | input | 5 | Immediate shift amount |
| amt_reg | input | 32 | Register whose low byte supplies the amount |
| carry_in | input | 1 | Current carry flag |
| operand | output | 32 | Resulting second operand |
| carry_out | output | 1 | Shifter carry |

## Verification
The bench builds the block with its default parameters: a 32-bit word, an 8-bit register amount and a 4-bit rotate count. With these values every boundary amount is reachable, namely 0, 1, 31, 32, 33, 64 and 255. The 4-bit count also reaches the largest immediate rotation of 30. A reference model in the bench moves the value one place per step and records each bit that leaves it. This gives expected results for all amount rules without reusing the block's wide-shift formulation.

// File: rtl/opsh_pkg.sv
package opsh_pkg;
   typedef enum logic [2:0] {
      SK_LSL = 3'd0,
      SK_LSR = 3'd1,
      SK_ASR = 3'd2,
      SK_ROR = 3'd3,
      SK_RRX = 3'd4
   } shift_kind_e;
endpackage

// File: rtl/opsh_amt.sv
module opsh_amt #(
   parameter int W    = 32,
   parameter int SAW  = 5,
   parameter int AW   = 8
) (
   input  logic           sel_reg,
   input  logic [SAW-1:0] imm_amt,
   input  logic [W-1:0]   reg_amt,
   output logic [AW-1:0]  amt
);
   generate
      if (AW < SAW || AW > W) begin : g_bad
         $error("opsh_amt: AW must lie between SAW and W");
      end
   endgenerate

   logic unused_reg_hi;
   assign unused_reg_hi = ^reg_amt[W-1:AW];

   always_comb begin
      if (sel_reg) amt = reg_amt[AW-1:0];
      else         amt = {{(AW-SAW){1'b0}}, imm_amt};
   end

   always_comb begin
      if (!sel_reg)
         p_imm_amt_small_r6: assert (amt < (1 << SAW))
            else $error("immediate amount out of range");
   end
endmodule

// File: rtl/opsh_core.sv
module opsh_core
   import opsh_pkg::*;
#(
   parameter int W  = 32,
   parameter int AW = 8
) (
   input  logic [W-1:0]  val,
   input  shift_kind_e   kind,
   input  logic [AW-1:0] amt,
   input  logic          cin,
   output logic [W-1:0]  res,
   output logic          cout
);
   localparam int IW = $clog2(W);

   generate
      if (W != (1 << IW)) begin : g_bad_w
         $error("opsh_core: W must be a power of two");
      end
      if ((1 << AW) <= W) begin : g_bad_aw
         $error("opsh_core: AW must reach past W");
      end
   endgenerate

   logic [IW-1:0]  low;
   logic           amt_zero, amt_eq_w, amt_ge_w;
   logic [W:0]     lsl_wide;
   logic [W:0]     lsr_wide;
   logic [W:0]     asr_wide;
   logic [2*W-1:0] ror_wide;

   assign low      = amt[IW-1:0];
   assign amt_zero = (amt == '0);
   assign amt_eq_w = (amt == AW'(W));
   assign amt_ge_w = (amt >= AW'(W));

   assign lsl_wide = {1'b0, val} << low;
   assign lsr_wide = {val, 1'b0} >> low;
   assign asr_wide = W'($signed({val, 1'b0}) >>> low);
   assign ror_wide = {val, val} >> low;

   always_comb begin
      res  = val;
      cout = cin;
      unique case (kind)
         SK_LSL: begin
            if (amt_zero) begin
               res = val; cout = cin;
            end else if (amt_eq_w) begin
               res = '0; cout = val[0];
            end else if (amt_ge_w) begin
               res = '0; cout = 1'b0;
            end else begin
               res = lsl_wide[W-1:0]; cout = lsl_wide[W];
            end
         end
         SK_LSR: begin
            if (amt_zero) begin
               res = val; cout = cin;
            end else if (amt_eq_w) begin
               res = '0; cout = val[W-1];
            end else if (amt_ge_w) begin
               res = '0; cout = 1'b0;
            end else begin
               res = lsr_wide[W:1]; cout = lsr_wide[0];
            end
         end
         SK_ASR: begin
            if (amt_zero) begin
               res = val; cout = cin;
            end else if (amt_ge_w) begin
               res = {W{val[W-1]}}; cout = val[W-1];
            end else begin
               res = asr_wide[W:1]; cout = asr_wide[0];
            end
         end
         SK_ROR: begin
            if (amt_zero) begin
               res = val; cout = cin;
            end else begin
               res = ror_wide[W-1:0]; cout = ror_wide[W-1];
            end
         end
         SK_RRX: begin
            res = {cin, val[W-1:1]}; cout = val[0];
         end
         default: begin
            res = val; cout = cin;
         end
      endcase
   end

   always_comb begin
      if (kind == SK_LSL && !amt_ge_w && !amt_zero)
         p_lsl_zero_fill_r1: assert ((res & ((W'(1) << low) - W'(1))) == '0)
            else $error("left shift filled non-zero bits");
      if (kind == SK_ASR && amt_ge_w)
         p_asr_sign_flood_r9: assert ($countones(res) == 0 || $countones(res) == W)
            else $error("arithmetic shift past width not uniform");
      if (kind == SK_RRX)
         p_rrx_top_carry_r5: assert (res[W-1] == cin)
            else $error("rotate through carry lost the carry");
      if (kind == SK_ROR)
         p_ror_keeps_ones_r4: assert ($countones(res) == $countones(val))
            else $error("rotate changed the number of ones");
      if (amt_zero && kind != SK_RRX)
         p_zero_amt_passes_r7: assert (cout == cin && res == val)
            else $error("zero amount altered the operand");
   end
endmodule

// File: rtl/opsh_imm.sv
module opsh_imm #(
   parameter int W    = 32,
   parameter int VW   = 8,
   parameter int ROTW = 4
) (
   input  logic [ROTW+VW-1:0] field,
   input  logic               cin,
   output logic [W-1:0]       res,
   output logic               cout
);
   generate
      if ((1 << (ROTW + 1)) > W) begin : g_bad_rot
         $error("opsh_imm: rotate count reaches past the word");
      end
      if (VW > W) begin : g_bad_vw
         $error("opsh_imm: value wider than word");
      end
   endgenerate

   logic [ROTW-1:0] rot;
   logic [W-1:0]    stage [ROTW+1];

   assign rot      = field[ROTW+VW-1:VW];
   assign stage[0] = {{(W-VW){1'b0}}, field[VW-1:0]};

   for (genvar k = 0; k < ROTW; k++) begin : g_rot
      localparam int R = 2 << k;
      assign stage[k+1] = rot[k] ? {stage[k][R-1:0], stage[k][W-1:R]} : stage[k];
   end

   assign res  = stage[ROTW];
   assign cout = (rot == '0) ? cin : stage[ROTW][W-1];

   always_comb begin
      p_imm_ones_kept_r11: assert ($countones(res) == $countones(field[VW-1:0]))
         else $error("immediate expansion changed bit count");
      if (rot == '0)
         p_imm_carry_pass_r12: assert (cout == cin && res[W-1:VW] == '0)
            else $error("zero rotation altered carry or value");
   end
endmodule

// File: rtl/opsh_top.sv
module opsh_top
   import opsh_pkg::*;
#(
   parameter int W    = 32,
   parameter int SAW  = 5,
   parameter int AW   = 8,
   parameter int VW   = 8,
   parameter int ROTW = 4
) (
   input  logic                imm_mode,
   input  logic [ROTW+VW-1:0]  imm_field,
   input  logic [W-1:0]        src_val,
   input  logic [2:0]          shift_kind,
   input  logic                amt_sel_reg,
   input  logic [SAW-1:0]      amt_imm,
   input  logic [W-1:0]        amt_reg,
   input  logic                carry_in,
   output logic [W-1:0]        operand,
   output logic                carry_out
);
   generate
      if ((1 << SAW) != W) begin : g_bad_saw
         $error("opsh_top: SAW must address every bit of W");
      end
   endgenerate

   logic [AW-1:0] amt;
   logic [W-1:0]  sh_res, im_res;
   logic          sh_c, im_c;

   opsh_amt #(.W(W), .SAW(SAW), .AW(AW)) u_amt (
      .sel_reg (amt_sel_reg),
      .imm_amt (amt_imm),
      .reg_amt (amt_reg),
      .amt     (amt)
   );

   opsh_core #(.W(W), .AW(AW)) u_core (
      .val  (src_val),
      .kind (shift_kind_e'(shift_kind)),
      .amt  (amt),
      .cin  (carry_in),
      .res  (sh_res),
      .cout (sh_c)
   );

   opsh_imm #(.W(W), .VW(VW), .ROTW(ROTW)) u_imm (
      .field (imm_field),
      .cin   (carry_in),
      .res   (im_res),
      .cout  (im_c)
   );

   assign operand   = imm_mode ? im_res : sh_res;
   assign carry_out = imm_mode ? im_c   : sh_c;
endmodule

// File: tb/opsh_top_bench.sv
module opsh_top_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        imm_mode;
   logic [11:0] imm_field;
   logic [31:0] src_val;
   logic [2:0]  shift_kind;
   logic        amt_sel_reg;
   logic [4:0]  amt_imm;
   logic [31:0] amt_reg;
   logic        carry_in;
   logic [31:0] operand;
   logic        carry_out;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   opsh_top u_opsh_top (
      .imm_mode(imm_mode), .imm_field(imm_field), .src_val(src_val),
      .shift_kind(shift_kind), .amt_sel_reg(amt_sel_reg), .amt_imm(amt_imm),
      .amt_reg(amt_reg), .carry_in(carry_in), .operand(operand), .carry_out(carry_out)
   );

   // Step-by-step reference: one place per step, recording the departing bit.
   function automatic logic [32:0] model(input logic [2:0] k, input logic [31:0] v,
                                         input int a, input logic c);
      logic [31:0] x = v;
      logic cy = c;
      int n;
      if (k == 3'd4) return {v[0], c, v[31:1]};
      if (a == 0) return {c, v};
      case (k)
         3'd0: begin
            n = (a > 33) ? 33 : a;
            for (int i = 0; i < n; i++) begin cy = x[31]; x = {x[30:0], 1'b0}; end
         end
         3'd1: begin
            n = (a > 33) ? 33 : a;
            for (int i = 0; i < n; i++) begin cy = x[0]; x = {1'b0, x[31:1]}; end
         end
         3'd2: begin
            n = (a > 32) ? 32 : a;
            for (int i = 0; i < n; i++) begin cy = x[0]; x = {x[31], x[31:1]}; end
         end
         default: begin
            n = a % 32;
            if (n == 0) cy = x[31];
            for (int i = 0; i < n; i++) begin cy = x[0]; x = {x[0], x[31:1]}; end
         end
      endcase
      return {cy, x};
   endfunction

   function automatic logic [32:0] imodel(input logic [11:0] f, input logic c);
      logic [31:0] x = {24'd0, f[7:0]};
      int r = 2 * int'(f[11:8]);
      for (int i = 0; i < r; i++) x = {x[0], x[31:1]};
      return {(r == 0) ? c : x[31], x};
   endfunction

   task automatic check(input string req, input logic [31:0] exp_v, input logic exp_c);
      #1;
      checks++;
      if (operand !== exp_v || carry_out !== exp_c) begin
         errors++;
         $display("FAIL %s: got operand=%h carry=%b, expected operand=%h carry=%b",
                  req, operand, carry_out, exp_v, exp_c);
      end
      @(negedge clk);
   endtask

   task automatic run_reg(input string req, input logic [2:0] k, input logic [31:0] v,
                          input bit use_reg, input logic [31:0] ra, input logic [4:0] ia,
                          input logic c);
      logic [32:0] e;
      int a = use_reg ? int'(ra[7:0]) : int'(ia);
      imm_mode = 0; shift_kind = k; src_val = v; amt_sel_reg = use_reg;
      amt_reg = ra; amt_imm = ia; carry_in = c;
      e = model(k, v, a, c);
      check(req, e[31:0], e[32]);
   endtask

   task automatic run_imm(input string req, input logic [11:0] f, input logic c,
                          input logic [31:0] exp_v, input logic exp_c);
      logic [32:0] e;
      imm_mode = 1; imm_field = f; carry_in = c;
      e = imodel(f, c);
      if (e[31:0] !== exp_v) begin
         checks++; errors++;
         $display("FAIL %s: model %h disagrees with stated %h", req, e[31:0], exp_v);
      end
      check(req, exp_v, exp_c);
   endtask

   task automatic t_reset;
      check("R7 reset", 32'h0, 1'b0);
   endtask

   task automatic t_lsl_r1;
      run_reg("R1", 3'd0, 32'h8000_0001, 0, 0, 5'd1, 0);
      run_reg("R1", 3'd0, 32'h1234_5678, 0, 0, 5'd31, 1);
      run_reg("R1", 3'd0, 32'hF0F0_1234, 0, 0, 5'd4, 0);
   endtask

   task automatic t_lsr_r2;
      run_reg("R2", 3'd1, 32'hA000_0003, 0, 0, 5'd2, 0);
      run_reg("R2", 3'd1, 32'h8000_0000, 0, 0, 5'd31, 0);
   endtask

   task automatic t_asr_r3;
      run_reg("R3", 3'd2, 32'h8000_0010, 0, 0, 5'd5, 0);
      run_reg("R3", 3'd2, 32'h7FFF_FFFF, 0, 0, 5'd1, 0);
   endtask

   task automatic t_ror_r4;
      run_reg("R4", 3'd3, 32'h0000_0001, 0, 0, 5'd1, 0);
      run_reg("R4", 3'd3, 32'h1234_5678, 0, 0, 5'd12, 0);
   endtask

   task automatic t_rrx_r5;
      run_reg("R5", 3'd4, 32'h0000_0003, 0, 0, 5'd7, 1);
      run_reg("R5", 3'd4, 32'hFFFF_FFFE, 1, 32'd40, 5'd0, 0);
      check("R5 stated", 32'h7FFF_FFFF, 1'b0);
   endtask

   task automatic t_src_r6;
      run_reg("R6", 3'd1, 32'hF000_0000, 1, 32'hFFFF_FF04, 5'd9, 0);
      check("R6 stated", 32'h0F00_0000, 1'b0);
      run_reg("R6", 3'd0, 32'h0000_00FF, 0, 32'h0000_0010, 5'd8, 0);
   endtask

   task automatic t_zero_r7;
      for (int k = 0; k < 4; k++)
         run_reg("R7", 3'(k), 32'hDEAD_BEEF, 1, 32'h0000_0100, 5'd3, 1);
   endtask

   task automatic t_big_r8;
      run_reg("R8", 3'd0, 32'h0000_0001, 1, 32'd32, 0, 0);
      check("R8 stated", 32'h0, 1'b1);
      run_reg("R8", 3'd1, 32'h8000_0000, 1, 32'd32, 0, 0);
      run_reg("R8", 3'd0, 32'hFFFF_FFFF, 1, 32'd33, 0, 1);
      run_reg("R8", 3'd1, 32'hFFFF_FFFF, 1, 32'd255, 0, 1);
   endtask

   task automatic t_asr_big_r9;
      run_reg("R9", 3'd2, 32'h8000_0000, 1, 32'd32, 0, 0);
      run_reg("R9", 3'd2, 32'h7FFF_FFFF, 1, 32'd200, 0, 1);
   endtask

   task automatic t_ror_mod_r10;
      run_reg("R10", 3'd3, 32'h8000_0005, 1, 32'd64, 0, 0);
      check("R10 stated", 32'h8000_0005, 1'b1);
      run_reg("R10", 3'd3, 32'h0000_0002, 1, 32'd33, 0, 0);
   endtask

   task automatic t_imm_r11_r12;
      run_imm("R11", 12'hD40, 1'b1, 32'h0000_1000, 1'b0);
      run_imm("R11", 12'h8FF, 1'b1, 32'h00FF_0000, 1'b0);
      run_imm("R12", 12'h0AB, 1'b1, 32'h0000_00AB, 1'b1);
      run_imm("R12", 12'h1FF, 1'b0, 32'hC000_003F, 1'b1);
      run_imm("R11", 12'hF01, 1'b0, 32'h0000_0004, 1'b0);
   endtask

   initial begin
      imm_mode = 0; imm_field = 0; src_val = 0; shift_kind = 0;
      amt_sel_reg = 0; amt_imm = 0; amt_reg = 0; carry_in = 0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_lsl_r1();
      t_lsr_r2();
      t_asr_r3();
      t_ror_r4();
      t_rrx_r5();
      t_src_r6();
      t_zero_r7();
      t_big_r8();
      t_asr_big_r9();
      t_ror_mod_r10();
      t_imm_r11_r12();
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (5000) @(posedge clk);
            checks++; errors++;
            $display("FAIL watchdog: got timeout, expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule